// File: doc/BRIEF.md
# Nibble-Serial Firmware Bus Write Target

This block is the target side of a 4-bit multiplexed firmware bus. It accepts single-byte write cycles. The host lowers an active-low frame strobe while it presents a start code. It then sends, one nibble per clock, an ID-select nibble, a 28-bit address, a size nibble and a data byte. The target checks the ID against its strap pins and checks that the size means one byte. It then takes the bus across a two-clock turnaround, returns an acknowledge nibble, parks the bus high and hands it back to the host.

On the clock that carries the acknowledge, the block raises a one-clock write strobe together with the captured address and byte. Flash logic behind it uses these to program the array or to interpret a command. Tri-state control is modelled by a separate output-enable line beside the driven nibble. Any clock edge with the frame strobe low restarts decoding, so a new start aborts a cycle that is in progress.

Top module: `nibble_wr_target`

## Requirements
- R1: While reset is high and on the first clock after it, `bus_oe` and `wr_stb` are 0.
- R2: A cycle starts only when the nibble 4'b1110 is sampled with `frame_n` low. If `frame_n` stays low for several clocks, only the nibble sampled on the last low clock decides whether a cycle starts.
- R3: The nibble after the start is compared with `id_strap`. On a mismatch, neither `bus_oe` nor `wr_stb` is asserted for that cycle.
- R4: The seven nibbles after the ID form `wr_addr`, most-significant nibble first.
- R5: The nibble after the address must be 4'b0000. Any other value ends the cycle, and neither `bus_oe` nor `wr_stb` is asserted.
- R6: The two data nibbles form `wr_data`, least-significant nibble first. `wr_data` and `wr_addr` are stable while `wr_stb` is high.
- R7: `bus_oe` stays 0 through the clock that samples the high data nibble and through the host turnaround clock. From the second turnaround clock (after the 13th edge of the cycle), the target enables its output and drives 4'b1111.
- R8: After the 14th edge, the target drives 4'b0000 with `bus_oe` high. `wr_stb` is high for exactly that one clock.
- R9: After the 15th edge, the target drives 4'b1111. After the 16th edge, `bus_oe` is 0.
- R10: `frame_n` low in the middle of a cycle aborts it. Decoding restarts, and a following complete cycle is acknowledged with its own address and data.
- R11: After a rejected cycle, nibbles sampled with `frame_n` high, including 4'b1110, are ignored until a valid start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all fields sampled on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| frame_n | input | 1 | Active-low frame strobe from the host |
| bus_in | input | 4 | Nibble sampled from the shared bus |
| id_strap | input | 4 | Device ID strap pins |
| bus_out | output | 4 | Nibble the target drives when enabled |
| bus_oe | output | 1 | Output enable standing in for the tri-state control |
| wr_stb | output | 1 | One-clock write strobe |
| wr_addr | output | 28 | Captured write address |
| wr_data | output | 8 | Captured write byte |

## Verification
The edges of a cycle are counted from the one that samples the start nibble. Output enable must still be low after edge 12 and turns on after edge 13. The acknowledge nibble, the strobe, the address and the data are due after edge 14, the park nibble after edge 15, and the release after edge 16. The bench drives every nibble on a falling edge and reads the outputs on the next falling edge, so each check lands in the cycle that follows the edge it refers to. For rejected, aborted and ignored cycles, the bench watches enable and strobe over the whole window and checks that neither ever rose.

// File: rtl/nwt_pkg.sv
package nwt_pkg;

    localparam int NIB_W = 4;

    localparam logic [NIB_W-1:0] START_CODE = 4'b1110;
    localparam logic [NIB_W-1:0] ACK_CODE   = 4'b0000;
    localparam logic [NIB_W-1:0] PARK_CODE  = 4'b1111;
    localparam logic [NIB_W-1:0] ONE_BYTE   = 4'b0000;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_IDSEL,
        PH_ADDR,
        PH_SIZE,
        PH_DATA,
        PH_HOST_TAR,
        PH_TGT_TAR,
        PH_ACK,
        PH_TGT_PARK
    } phase_e;

    typedef struct packed {
        logic             oe;
        logic [NIB_W-1:0] nib;
        logic             stb;
    } drive_t;

    function automatic drive_t drive_for(phase_e p);
        drive_t d;
        d.oe  = 1'b0;
        d.nib = PARK_CODE;
        d.stb = 1'b0;
        case (p)
            PH_TGT_TAR:  d.oe = 1'b1;
            PH_ACK: begin
                d.oe  = 1'b1;
                d.nib = ACK_CODE;
                d.stb = 1'b1;
            end
            PH_TGT_PARK: d.oe = 1'b1;
            default: ;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/nwt_sequencer.sv
module nwt_sequencer
    import nwt_pkg::*;
#(
    parameter int ADDR_NIBS = 7,
    parameter int DATA_NIBS = 2,
    parameter int CNT_W     = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_n,
    input  logic [NIB_W-1:0] bus_in,
    input  logic [NIB_W-1:0] id_strap,
    output phase_e           phase,
    output logic [CNT_W-1:0] slot,
    output logic             addr_en,
    output logic             data_en
);

    phase_e           phase_nxt;
    logic [CNT_W-1:0] slot_nxt;

    assign addr_en = frame_n && (phase == PH_ADDR);
    assign data_en = frame_n && (phase == PH_DATA);

    always_comb begin
        phase_nxt = phase;
        slot_nxt  = slot;
        if (!frame_n) begin
            phase_nxt = (bus_in == START_CODE) ? PH_IDSEL : PH_IDLE;
            slot_nxt  = '0;
        end else begin
            case (phase)
                PH_IDLE: phase_nxt = PH_IDLE;
                PH_IDSEL: begin
                    phase_nxt = (bus_in == id_strap) ? PH_ADDR : PH_IDLE;
                    slot_nxt  = '0;
                end
                PH_ADDR: begin
                    if (slot == CNT_W'(ADDR_NIBS - 1)) begin
                        phase_nxt = PH_SIZE;
                        slot_nxt  = '0;
                    end else begin
                        slot_nxt = slot + 1'b1;
                    end
                end
                PH_SIZE: begin
                    phase_nxt = (bus_in == ONE_BYTE) ? PH_DATA : PH_IDLE;
                    slot_nxt  = '0;
                end
                PH_DATA: begin
                    if (slot == CNT_W'(DATA_NIBS - 1)) begin
                        phase_nxt = PH_HOST_TAR;
                        slot_nxt  = '0;
                    end else begin
                        slot_nxt = slot + 1'b1;
                    end
                end
                PH_HOST_TAR: phase_nxt = PH_TGT_TAR;
                PH_TGT_TAR:  phase_nxt = PH_ACK;
                PH_ACK:      phase_nxt = PH_TGT_PARK;
                PH_TGT_PARK: phase_nxt = PH_IDLE;
                default:     phase_nxt = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            slot  <= '0;
        end else begin
            phase <= phase_nxt;
            slot  <= slot_nxt;
        end
    end

endmodule

// File: rtl/nwt_capture.sv
module nwt_capture
    import nwt_pkg::*;
#(
    parameter int ADDR_W = 28,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NIB_W-1:0]  bus_in,
    input  logic              addr_en,
    input  logic              data_en,
    input  logic [CNT_W-1:0]  slot,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] data_q
);

    localparam int DATA_NIBS = DATA_W / NIB_W;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
        end else if (addr_en) begin
            addr_q <= {addr_q[ADDR_W-NIB_W-1:0], bus_in};
        end
    end

    for (genvar k = 0; k < DATA_NIBS; k++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) begin
                data_q[k*NIB_W +: NIB_W] <= '0;
            end else if (data_en && (slot == CNT_W'(k))) begin
                data_q[k*NIB_W +: NIB_W] <= bus_in;
            end
        end
    end

endmodule

// File: rtl/nwt_driver.sv
module nwt_driver
    import nwt_pkg::*;
(
    input  phase_e           phase,
    output logic             oe,
    output logic [NIB_W-1:0] nib,
    output logic             stb
);

    drive_t d;

    always_comb begin
        d   = drive_for(phase);
        oe  = d.oe;
        nib = d.nib;
        stb = d.stb;
    end

endmodule

// File: rtl/nibble_wr_target.sv
module nibble_wr_target
    import nwt_pkg::*;
#(
    parameter int ADDR_W = 28,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_n,
    input  logic [3:0]        bus_in,
    input  logic [3:0]        id_strap,
    output logic [3:0]        bus_out,
    output logic              bus_oe,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);

    localparam int ADDR_NIBS = ADDR_W / NIB_W;
    localparam int DATA_NIBS = DATA_W / NIB_W;
    localparam int MAX_NIBS  = (ADDR_NIBS > DATA_NIBS) ? ADDR_NIBS : DATA_NIBS;
    localparam int CNT_W     = (MAX_NIBS > 1) ? $clog2(MAX_NIBS) : 1;

    phase_e           phase;
    logic [CNT_W-1:0] slot;
    logic             addr_en;
    logic             data_en;

    nwt_sequencer #(
        .ADDR_NIBS(ADDR_NIBS),
        .DATA_NIBS(DATA_NIBS),
        .CNT_W    (CNT_W)
    ) seq_i (
        .clk     (clk),
        .rst     (rst),
        .frame_n (frame_n),
        .bus_in  (bus_in),
        .id_strap(id_strap),
        .phase   (phase),
        .slot    (slot),
        .addr_en (addr_en),
        .data_en (data_en)
    );

    nwt_capture #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .CNT_W (CNT_W)
    ) cap_i (
        .clk    (clk),
        .rst    (rst),
        .bus_in (bus_in),
        .addr_en(addr_en),
        .data_en(data_en),
        .slot   (slot),
        .addr_q (wr_addr),
        .data_q (wr_data)
    );

    nwt_driver drv_i (
        .phase(phase),
        .oe   (bus_oe),
        .nib  (bus_out),
        .stb  (wr_stb)
    );

endmodule

// File: rtl/nwt_checker.sv
module nwt_checker
    import nwt_pkg::*;
#(
    parameter int ADDR_W = 28,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              frame_n,
    input logic [3:0]        bus_out,
    input logic              bus_oe,
    input logic              wr_stb,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data
);

    logic rst_q;
    always_ff @(posedge clk) rst_q <= rst;

    // R1
    always @(posedge clk) begin
        if (rst_q === 1'b1) begin
            rst_quiet_chk: assert (!bus_oe && !wr_stb);
        end
    end

    // R7
    grab_park_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_oe) |-> (bus_out == PARK_CODE) && !wr_stb);

    // R7
    grab_then_ack_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(bus_oe) && frame_n) |=> wr_stb);

    // R8
    ack_nib_chk: assert property (@(posedge clk) disable iff (rst)
        wr_stb |-> bus_oe && (bus_out == ACK_CODE));

    // R8
    stb_single_chk: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> !wr_stb);

    // R9
    park_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && frame_n) |=> bus_oe && (bus_out == PARK_CODE));

    // R6
    capture_hold_chk: assert property (@(posedge clk) disable iff (rst)
        wr_stb |-> $stable(wr_addr) && $stable(wr_data));

endmodule

bind nibble_wr_target nwt_checker #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
) chk_i (
    .clk    (clk),
    .rst    (rst),
    .frame_n(frame_n),
    .bus_out(bus_out),
    .bus_oe (bus_oe),
    .wr_stb (wr_stb),
    .wr_addr(wr_addr),
    .wr_data(wr_data)
);

// File: tb/nibble_wr_target_tb.sv
`timescale 1ns/1ps
module nibble_wr_target_tb_top;

    localparam logic [3:0] MY_ID = 4'h9;

    logic        clk = 1'b0;
    logic        rst;
    logic        frame_n;
    logic [3:0]  bus_in;
    logic [3:0]  id_strap;
    logic [3:0]  bus_out;
    logic        bus_oe;
    logic        wr_stb;
    logic [27:0] wr_addr;
    logic [7:0]  wr_data;

    int checks = 0;
    int errors = 0;
    bit seen_oe;
    bit seen_stb;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    nibble_wr_target dut_i (
        .clk     (clk),
        .rst     (rst),
        .frame_n (frame_n),
        .bus_in  (bus_in),
        .id_strap(id_strap),
        .bus_out (bus_out),
        .bus_oe  (bus_oe),
        .wr_stb  (wr_stb),
        .wr_addr (wr_addr),
        .wr_data (wr_data)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive at a falling edge, return at the falling edge after the sampling edge
    task automatic step(input logic f, input logic [3:0] nib);
        frame_n = f;
        bus_in  = nib;
        @(posedge clk);
        @(negedge clk);
        seen_oe  = seen_oe  | bus_oe;
        seen_stb = seen_stb | wr_stb;
    endtask

    task automatic send_body(input logic [3:0] id, input logic [27:0] a,
                             input logic [3:0] sz, input logic [7:0] d);
        step(1'b1, id);
        for (int i = 6; i >= 0; i--) step(1'b1, a[i*4 +: 4]);
        step(1'b1, sz);
        step(1'b1, d[3:0]);
        step(1'b1, d[7:4]);
    endtask

    task automatic expect_ack(input logic [27:0] ea, input logic [7:0] ed, input string tag);
        chk(bus_oe == 1'b0, {"R7 oe low after data ", tag}, 32'(bus_oe), 32'd0);
        step(1'b1, 4'hF);
        chk(bus_oe && bus_out == 4'hF && !wr_stb, {"R7 target grabs bus ", tag},
            {bus_oe, wr_stb, bus_out}, 32'h0000002F);
        step(1'b1, 4'hF);
        chk(bus_oe && bus_out == 4'h0 && wr_stb, {"R8 ack nibble and strobe ", tag},
            {bus_oe, wr_stb, bus_out}, 32'h00000030);
        chk(wr_addr == ea, {"R4 address ", tag}, 32'(wr_addr), 32'(ea));
        chk(wr_data == ed, {"R6 data ", tag}, 32'(wr_data), 32'(ed));
        step(1'b1, 4'hF);
        chk(bus_oe && bus_out == 4'hF && !wr_stb, {"R9 park nibble ", tag},
            {bus_oe, wr_stb, bus_out}, 32'h0000002F);
        step(1'b1, 4'hF);
        chk(!bus_oe && !wr_stb, {"R9 release ", tag}, {bus_oe, wr_stb}, 32'd0);
    endtask

    task automatic expect_quiet(input string tag);
        for (int i = 0; i < 6; i++) step(1'b1, 4'hF);
        chk(!seen_oe && !seen_stb, tag, {seen_oe, seen_stb}, 32'd0);
    endtask

    task automatic t_reset;
        rst = 1'b1; frame_n = 1'b1; bus_in = 4'hF; id_strap = MY_ID;
        repeat (3) @(negedge clk);
        chk(!bus_oe && !wr_stb, "R1 reset quiet", {bus_oe, wr_stb}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(!bus_oe && !wr_stb, "R1 after reset", {bus_oe, wr_stb}, 32'd0);
    endtask

    task automatic t_basic;
        step(1'b0, 4'hE);
        send_body(MY_ID, 28'h1234567, 4'h0, 8'hA5);
        expect_ack(28'h1234567, 8'hA5, "basic R2");
    endtask

    task automatic t_pattern;
        step(1'b0, 4'hE);
        send_body(MY_ID, 28'hFEDCBA9, 4'h0, 8'h3C);
        expect_ack(28'hFEDCBA9, 8'h3C, "pattern");
    endtask

    task automatic t_double_start;
        step(1'b0, 4'hE);
        step(1'b0, 4'hE);
        send_body(MY_ID, 28'h0F0F0F0, 4'h0, 8'h81);
        expect_ack(28'h0F0F0F0, 8'h81, "R2 double start");
    endtask

    task automatic t_start_overridden;
        seen_oe = 1'b0; seen_stb = 1'b0;
        step(1'b0, 4'hE);
        step(1'b0, 4'h5);
        send_body(MY_ID, 28'h1111111, 4'h0, 8'h22);
        expect_quiet("R2 last low nibble not start");
    endtask

    task automatic t_id_mismatch;
        seen_oe = 1'b0; seen_stb = 1'b0;
        step(1'b0, 4'hE);
        send_body(4'h3, 28'h2222222, 4'h0, 8'h44);
        expect_quiet("R3 id mismatch");
        seen_oe = 1'b0; seen_stb = 1'b0;
        step(1'b1, 4'hE);
        send_body(MY_ID, 28'h3333333, 4'h0, 8'h55);
        expect_quiet("R11 ignored without frame");
        step(1'b0, 4'hE);
        send_body(MY_ID, 28'h7654321, 4'h0, 8'h96);
        expect_ack(28'h7654321, 8'h96, "R11 next valid start");
    endtask

    task automatic t_bad_size;
        seen_oe = 1'b0; seen_stb = 1'b0;
        step(1'b0, 4'hE);
        send_body(MY_ID, 28'h4444444, 4'h1, 8'h66);
        expect_quiet("R5 size not one byte");
    endtask

    task automatic t_abort;
        seen_oe = 1'b0; seen_stb = 1'b0;
        step(1'b0, 4'hE);
        step(1'b1, MY_ID);
        step(1'b1, 4'hA);
        step(1'b1, 4'hB);
        step(1'b1, 4'hC);
        step(1'b0, 4'hE);
        send_body(MY_ID, 28'h0ABCDEF, 4'h0, 8'h5A);
        chk(!seen_oe && !seen_stb, "R10 no drive before restart ack", {seen_oe, seen_stb}, 32'd0);
        expect_ack(28'h0ABCDEF, 8'h5A, "R10 abort restart");
    endtask

    initial begin
        @(negedge clk);
        t_reset;
        t_basic;
        t_pattern;
        t_double_start;
        t_start_overridden;
        t_id_mismatch;
        t_bad_size;
        t_abort;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule